// File: doc/BRIEF.md
# Windowed Batch Buffer Sizer

This block decides how much buffer space each of a group of accelerator requests receives. Requests are not served as they arrive. They are gathered over a fixed collection window, or until the batch is full, and the whole batch is then sized together. Each request describes a short curve of candidate operating points, ordered by increasing buffer size. Each point carries a buffer size and a precomputed efficiency figure, so the block never divides.

Sizing runs in two phases. First every request is placed at its smallest point. If even that does not fit the available capacity, the most recently collected request is set aside, and this repeats until the remainder fits. Then, step by step, the block moves one request to its next point: the one whose next point has the highest efficiency among those whose step keeps the total within capacity. Sizing ends when no step fits. The chosen points are reported one per cycle, followed by a completion pulse. Requests that were set aside stay queued and head the next batch. A buffer-free indication can start that batch early. A plain capacity comparison stands in for detailed placement.

Top module: `batch_alloc`

## Requirements
- R1: After reset, push_ready is 1, and grant_valid and batch_done are 0.
- R2: With fewer than N_REQ requests held, a batch starts after WINDOW cycles of collection, counted from reset or from the previous completion pulse. Each completion pulse therefore comes at least WINDOW cycles after the previous one.
- R3: When the last beat of the N_REQ-th held request is accepted, push_ready is 0 in the next cycle. The batch then starts without waiting for the window.
- R4: Every request in a batch starts at point index 0. While the sum of these sizes exceeds the sampled capacity, the request collected last is removed from the batch.
- R5: In each growth step, the candidates are requests that have a next point and whose step keeps the total at or below capacity. Among these, the one whose next point has the largest efficiency advances by one point. A tie goes to the request collected earlier. Growth stops when no candidate remains.
- R6: A request already at its last point never advances. A granted point index is always below that request's point count.
- R7: Grants appear one per cycle, in collection order. Each grant carries the request tag, a 0-based point index and the size of that point. batch_done is a one-cycle pulse in the cycle after the last grant, or after sizing when nothing is granted.
- R8: Requests removed under R4 stay queued, up to N_REQ of them. They are the earliest entries of the next batch, ahead of newly pushed requests.
- R9: When free_event is high during collection, at least one queued request is held, and no request is half pushed, the batch starts in the next cycle.
- R10: push_ready is 0 from batch start until the completion pulse. Beats offered while it is 0 are not taken.
- R11: Capacity is sampled when the batch starts. Later changes do not affect that batch.
- R12: A request is pushed as beats of {size, efficiency}, point 0 first. Its final beat is marked by push_last, and the N_PTS-th beat ends the request in any case. The tag is taken from the final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Curve beat offered |
| push_ready | output | 1 | Beat accepted this cycle when high |
| push_size | input | SIZE_W | Buffer size of this point |
| push_eff | input | EFF_W | Precomputed efficiency of this point |
| push_last | input | 1 | Final beat of the request |
| push_tag | input | TAG_W | Request tag, taken on the final beat |
| capacity | input | CAP_W | Available capacity, sampled at batch start |
| free_event | input | 1 | Buffer-free indication |
| grant_valid | output | 1 | Grant fields valid |
| grant_tag | output | TAG_W | Tag of the granted request |
| grant_point | output | PT_W | Chosen point index |
| grant_size | output | SIZE_W | Size of the chosen point |
| batch_done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets equal-efficiency ties. If the higher collection position wins a tie, the wrong request grows. It checks batches whose smallest points overflow capacity. Removing the wrong request, or losing it instead of queueing it, changes both the grants of this batch and the order of the next one. Other targets are a capacity change during sizing, which a design that reads the live input would follow, and early starts on a full batch or a free event. Each of those starts is timed, so a design that waited for the window would miss the expected completion cycle.

// File: rtl/batch_alloc_pkg.sv
package batch_alloc_pkg;
  typedef enum logic [2:0] {
    PH_COLLECT,
    PH_FIT,
    PH_READ,
    PH_EVAL,
    PH_APPLY,
    PH_GRANT
  } phase_t;
endpackage

// File: rtl/alloc_curve_ram.sv
module alloc_curve_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 40
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/alloc_window_timer.sv
module alloc_window_timer #(
  parameter int WINDOW = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic expired
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (run && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LAST);

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R2
endmodule

// File: rtl/alloc_step_judge.sv
module alloc_step_judge #(
  parameter int SIZE_W = 16,
  parameter int EFF_W  = 24,
  parameter int CAP_W  = 19,
  parameter int PT_W   = 3
) (
  input  logic [PT_W-1:0]   cur_pt,
  input  logic [PT_W:0]     npts,
  input  logic [SIZE_W-1:0] cur_sz,
  input  logic [SIZE_W-1:0] next_sz,
  input  logic [EFF_W-1:0]  next_eff,
  input  logic [CAP_W-1:0]  tot,
  input  logic [CAP_W-1:0]  cap,
  input  logic              have_best,
  input  logic [EFF_W-1:0]  best_eff,
  output logic              take
);
  logic [PT_W:0]  nxt_idx;
  logic [CAP_W:0] new_tot;
  logic           has_next, fits, better;

  always_comb begin
    nxt_idx  = {1'b0, cur_pt} + 1'b1;
    has_next = nxt_idx < npts;
    new_tot  = {1'b0, tot} - (CAP_W+1)'(cur_sz) + (CAP_W+1)'(next_sz);
    fits     = new_tot <= {1'b0, cap};
    better   = !have_best || (next_eff > best_eff);
    take     = has_next && fits && better;
  end
endmodule

// File: rtl/batch_alloc.sv
module batch_alloc
  import batch_alloc_pkg::*;
#(
  parameter int N_REQ  = 8,
  parameter int N_PTS  = 8,
  parameter int SIZE_W = 16,
  parameter int EFF_W  = 24,
  parameter int TAG_W  = 8,
  parameter int WINDOW = 10000,
  parameter int PT_W   = $clog2(N_PTS),
  parameter int CAP_W  = SIZE_W + $clog2(N_REQ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [SIZE_W-1:0] push_size,
  input  logic [EFF_W-1:0]  push_eff,
  input  logic              push_last,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic [CAP_W-1:0]  capacity,
  input  logic              free_event,
  output logic              grant_valid,
  output logic [TAG_W-1:0]  grant_tag,
  output logic [PT_W-1:0]   grant_point,
  output logic [SIZE_W-1:0] grant_size,
  output logic              batch_done
);
  localparam int SLOT_W = $clog2(N_REQ);
  localparam int CNT_W  = $clog2(N_REQ + 1);
  localparam int NPT_W  = PT_W + 1;
  localparam int ADDR_W = SLOT_W + PT_W;
  localparam int DATA_W = SIZE_W + EFF_W;
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(N_REQ);
  localparam logic [PT_W-1:0]  LAST_PT = PT_W'(N_PTS - 1);

  phase_t state;

  // Collection order: ord[i] is the physical slot at position i
  logic [SLOT_W-1:0] ord     [N_REQ];
  logic [SLOT_W-1:0] rot_ord [N_REQ];
  logic [PT_W-1:0]   cur     [N_REQ];
  logic [NPT_W-1:0]  npts    [N_REQ];
  logic [SIZE_W-1:0] cursz   [N_REQ];
  logic [TAG_W-1:0]  tags    [N_REQ];

  logic [CNT_W-1:0]  count, qcnt, nsel, j, best;
  logic [PT_W-1:0]   wp;
  logic              found;
  logic [EFF_W-1:0]  best_eff;
  logic [SIZE_W-1:0] best_sz;
  logic [CAP_W-1:0]  cap_q, tot, min_sum;

  logic              trig, accept, last_beat, tmr_exp, tmr_clear, take;
  logic [SLOT_W-1:0] wr_slot, phys_j, phys_b;
  logic [ADDR_W-1:0] raddr, waddr;
  logic [DATA_W-1:0] rdata;
  logic [SIZE_W-1:0] rd_sz;
  logic [EFF_W-1:0]  rd_eff;

  assign phys_j  = ord[j[SLOT_W-1:0]];
  assign phys_b  = ord[best[SLOT_W-1:0]];
  assign wr_slot = ord[count[SLOT_W-1:0]];
  assign rd_sz   = rdata[DATA_W-1 -: SIZE_W];
  assign rd_eff  = rdata[EFF_W-1:0];

  // Batch start conditions
  assign trig = (state == PH_COLLECT) && (wp == '0) && (count != '0) &&
                ((count == FULL) || tmr_exp || (free_event && (qcnt != '0)));
  assign push_ready = (state == PH_COLLECT) && (count < FULL) && !trig;
  assign accept     = push_valid && push_ready;
  assign last_beat  = push_last || (wp == LAST_PT);
  assign tmr_clear  = (state != PH_COLLECT) || (tmr_exp && (count == '0));

  assign waddr = {wr_slot, wp};
  assign raddr = {phys_j, cur[phys_j] + PT_W'(1)};

  alloc_curve_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_curves (
    .clk   (clk),
    .we    (accept),
    .waddr (waddr),
    .wdata ({push_size, push_eff}),
    .raddr (raddr),
    .rdata (rdata)
  );

  alloc_window_timer #(.WINDOW(WINDOW)) u_window (
    .clk     (clk),
    .rst     (rst),
    .run     (state == PH_COLLECT),
    .clear   (tmr_clear),
    .expired (tmr_exp)
  );

  alloc_step_judge #(
    .SIZE_W(SIZE_W), .EFF_W(EFF_W), .CAP_W(CAP_W), .PT_W(PT_W)
  ) u_judge (
    .cur_pt    (cur[phys_j]),
    .npts      (npts[phys_j]),
    .cur_sz    (cursz[phys_j]),
    .next_sz   (rd_sz),
    .next_eff  (rd_eff),
    .tot       (tot),
    .cap       (cap_q),
    .have_best (found),
    .best_eff  (best_eff),
    .take      (take)
  );

  // Sum of current sizes over the first nsel positions
  always_comb begin
    min_sum = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (CNT_W'(i) < nsel) min_sum = min_sum + CAP_W'(cursz[ord[i]]);
    end
  end

  // Leftover positions move to the front, keeping their order
  always_comb begin
    for (int i = 0; i < N_REQ; i++) begin
      rot_ord[i] = ord[SLOT_W'((i + int'(nsel)) % N_REQ)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= PH_COLLECT;
      count       <= '0;
      qcnt        <= '0;
      nsel        <= '0;
      j           <= '0;
      best        <= '0;
      wp          <= '0;
      found       <= 1'b0;
      best_eff    <= '0;
      best_sz     <= '0;
      cap_q       <= '0;
      tot         <= '0;
      grant_valid <= 1'b0;
      grant_tag   <= '0;
      grant_point <= '0;
      grant_size  <= '0;
      batch_done  <= 1'b0;
      for (int i = 0; i < N_REQ; i++) begin
        ord[i]   <= SLOT_W'(i);
        cur[i]   <= '0;
        npts[i]  <= '0;
        cursz[i] <= '0;
        tags[i]  <= '0;
      end
    end else begin
      grant_valid <= 1'b0;
      batch_done  <= 1'b0;
      unique case (state)
        PH_COLLECT: begin
          if (accept) begin
            if (wp == '0) begin
              cursz[wr_slot] <= push_size;
              cur[wr_slot]   <= '0;
            end
            if (last_beat) begin
              npts[wr_slot] <= NPT_W'(wp) + 1'b1;
              tags[wr_slot] <= push_tag;
              count         <= count + 1'b1;
              wp            <= '0;
            end else begin
              wp <= wp + 1'b1;
            end
          end
          if (trig) begin
            nsel  <= count;
            cap_q <= capacity;
            state <= PH_FIT;
          end
        end
        PH_FIT: begin
          if (min_sum <= cap_q) begin
            tot   <= min_sum;
            j     <= '0;
            found <= 1'b0;
            state <= PH_READ;
          end else begin
            nsel <= nsel - 1'b1;
          end
        end
        PH_READ: begin
          state <= (j == nsel) ? PH_APPLY : PH_EVAL;
        end
        PH_EVAL: begin
          if (take) begin
            found    <= 1'b1;
            best     <= j;
            best_eff <= rd_eff;
            best_sz  <= rd_sz;
          end
          j     <= j + 1'b1;
          state <= PH_READ;
        end
        PH_APPLY: begin
          j <= '0;
          if (found) begin
            cur[phys_b]   <= cur[phys_b] + 1'b1;
            cursz[phys_b] <= best_sz;
            tot           <= tot - CAP_W'(cursz[phys_b]) + CAP_W'(best_sz);
            found         <= 1'b0;
            state         <= PH_READ;
          end else begin
            state <= PH_GRANT;
          end
        end
        PH_GRANT: begin
          if (j != nsel) begin
            grant_valid <= 1'b1;
            grant_tag   <= tags[phys_j];
            grant_point <= cur[phys_j];
            grant_size  <= cursz[phys_j];
            j           <= j + 1'b1;
          end else begin
            batch_done <= 1'b1;
            count      <= count - nsel;
            qcnt       <= count - nsel;
            for (int i = 0; i < N_REQ; i++) ord[i] <= rot_ord[i];
            state      <= PH_COLLECT;
          end
        end
        default: state <= PH_COLLECT;
      endcase
    end
  end

  AST_GRANT_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> !push_ready); // R10
  AST_DONE_AFTER_GRANTS: assert property (@(posedge clk) disable iff (rst)
    ($past(grant_valid) && !grant_valid) |-> batch_done); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    batch_done |=> !batch_done); // R7
  AST_TOTAL_FITS: assert property (@(posedge clk) disable iff (rst)
    (state == PH_READ) |-> (tot <= cap_q)); // R5
  AST_HELD_LIMIT: assert property (@(posedge clk) disable iff (rst)
    count <= FULL); // R3
  AST_QUEUE_WITHIN_HELD: assert property (@(posedge clk) disable iff (rst)
    qcnt <= count); // R8
  AST_CAP_STABLE: assert property (@(posedge clk) disable iff (rst)
    (state != PH_COLLECT && $past(state) != PH_COLLECT) |-> $stable(cap_q)); // R11
endmodule

// File: tb/batch_alloc_test.sv
module batch_alloc_test;
  localparam int WIN   = 2000;
  localparam int CAPW  = 19;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_valid = 1'b0;
  logic        push_ready;
  logic [15:0] push_size = '0;
  logic [23:0] push_eff = '0;
  logic        push_last = 1'b0;
  logic [7:0]  push_tag = '0;
  logic [CAPW-1:0] capacity = '0;
  logic        free_event = 1'b0;
  logic        grant_valid;
  logic [7:0]  grant_tag;
  logic [2:0]  grant_point;
  logic [15:0] grant_size;
  logic        batch_done;

  batch_alloc #(.WINDOW(WIN)) uut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_ready(push_ready),
    .push_size(push_size), .push_eff(push_eff), .push_last(push_last),
    .push_tag(push_tag), .capacity(capacity), .free_event(free_event),
    .grant_valid(grant_valid), .grant_tag(grant_tag), .grant_point(grant_point),
    .grant_size(grant_size), .batch_done(batch_done)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          rq_n  [256];
  int unsigned rq_sz [256][8];
  int unsigned rq_ef [256][8];
  int nid = 0;
  int mq[8];  int mqn = 0;
  int bl[8];  int bn = 0;
  int ek;     int ept[8];
  int g_tag[16], g_pt[16], g_sz[16];
  int gc = 0, done_cnt = 0;
  longint done_cyc = 0, done_prev = 0, last_push_cyc = 0;
  logic prev_gv = 1'b0;

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (grant_valid) begin
        if (gc < 16) begin
          g_tag[gc] = int'(grant_tag); g_pt[gc] = int'(grant_point); g_sz[gc] = int'(grant_size);
        end
        gc++;
      end
      if (prev_gv && !grant_valid) chk(batch_done, "R7", "done after last grant", batch_done, 1);
      if (batch_done) begin
        chk(!grant_valid, "R7", "no grant with done", grant_valid, 0);
        done_prev = done_cyc;
        done_cyc  = cyc;
        done_cnt++;
      end
      prev_gv = grant_valid;
    end
  end

  initial begin
    while (cyc < 190000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run time", cyc, 190000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  function automatic int make_req(int n, int base);
    int id = nid;
    int s = base;
    nid++;
    rq_n[id] = n;
    for (int p = 0; p < n; p++) begin
      rq_sz[id][p] = s;
      rq_ef[id][p] = $urandom_range(0, 24'hFFFFFF);
      s = s + $urandom_range(1, 1000);
    end
    return id;
  endfunction

  task automatic push_one(int id);
    for (int p = 0; p < rq_n[id]; p++) begin
      @(negedge clk);
      while (!push_ready) @(negedge clk);
      push_valid = 1'b1;
      push_size  = 16'(rq_sz[id][p]);
      push_eff   = 24'(rq_ef[id][p]);
      push_last  = (p == rq_n[id] - 1);
      push_tag   = 8'(id);
      @(posedge clk);
    end
    @(negedge clk);
    push_valid = 1'b0;
    push_last  = 1'b0;
    last_push_cyc = cyc;
    bl[bn] = id; bn++;
  endtask

  task automatic begin_batch();
    bn = 0;
    for (int i = 0; i < mqn; i++) begin bl[bn] = mq[i]; bn++; end
    gc = 0;
  endtask

  task automatic wait_done();
    int start = done_cnt;
    while (done_cnt == start) @(negedge clk);
  endtask

  // Reference sizing from the requirements
  function automatic void model_run(int cap);
    int k = bn;
    int tot;
    int best, nt, id;
    int unsigned bef;
    int p[8];
    while (1) begin
      tot = 0;
      for (int i = 0; i < k; i++) tot += int'(rq_sz[bl[i]][0]);
      if (tot <= cap) break;
      k--;
    end
    for (int i = 0; i < 8; i++) p[i] = 0;
    while (1) begin
      best = -1; bef = 0;
      for (int i = 0; i < k; i++) begin
        id = bl[i];
        if (p[i] + 1 < rq_n[id]) begin
          nt = tot - int'(rq_sz[id][p[i]]) + int'(rq_sz[id][p[i]+1]);
          if (nt <= cap && (best < 0 || rq_ef[id][p[i]+1] > bef)) begin
            best = i; bef = rq_ef[id][p[i]+1];
          end
        end
      end
      if (best < 0) break;
      tot = tot - int'(rq_sz[bl[best]][p[best]]) + int'(rq_sz[bl[best]][p[best]+1]);
      p[best]++;
    end
    ek = k;
    for (int i = 0; i < 8; i++) ept[i] = p[i];
  endfunction

  task automatic finish_batch(int cap, string rq);
    wait_done();
    model_run(cap);
    chk(gc == ek, "R4", {rq, " grant count"}, gc, ek);
    for (int i = 0; i < ek && i < gc; i++) begin
      chk(g_tag[i] == (bl[i] & 255), "R7", {rq, " grant tag order"}, g_tag[i], bl[i] & 255);
      chk(g_pt[i] == ept[i], rq, "grant point", g_pt[i], ept[i]);
      chk(g_sz[i] == int'(rq_sz[bl[i]][ept[i]]), "R7", {rq, " grant size"},
          g_sz[i], rq_sz[bl[i]][ept[i]]);
      chk(g_pt[i] < rq_n[bl[i]], "R6", "point below count", g_pt[i], rq_n[bl[i]]);
    end
    mqn = 0;
    for (int i = ek; i < bn; i++) begin mq[mqn] = bl[i]; mqn++; end
  endtask

  initial begin
    int a, b, c, d, cap, nnew, tsum;
    longint t_rel, t_free;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_rel = cyc;
    done_cyc = cyc;
    @(negedge clk);
    // R1 reset state
    chk(push_ready == 1'b1, "R1", "ready after reset", push_ready, 1);
    chk(grant_valid == 1'b0, "R1", "grant after reset", grant_valid, 0);
    chk(batch_done == 1'b0, "R1", "done after reset", batch_done, 0);

    // R2 / R6: single request, window start, ample capacity
    capacity = 19'd60000;
    begin_batch();
    a = make_req(3, 100);
    push_one(a);
    finish_batch(60000, "R6");
    chk(g_pt[0] == 2, "R6", "top point reached", g_pt[0], 2);
    chk(done_cyc - t_rel >= WIN, "R2", "window wait", done_cyc - t_rel, WIN);

    // R5 tie: equal efficiencies, room for one step
    capacity = 19'd30;
    begin_batch();
    a = make_req(2, 10); rq_sz[a][1] = 20; rq_ef[a][1] = 5;
    b = make_req(2, 10); rq_sz[b][1] = 20; rq_ef[b][1] = 5;
    push_one(a); push_one(b);
    finish_batch(30, "R5");
    chk(g_pt[0] == 1 && g_pt[1] == 0, "R5", "tie to earlier", g_pt[0] * 10 + g_pt[1], 10);
    chk(done_cyc - done_prev >= WIN, "R2", "window wait again", done_cyc - done_prev, WIN);

    // R4 drop of the last request, R9 early start on free_event
    capacity = 19'd25;
    begin_batch();
    a = make_req(2, 10); b = make_req(2, 10); c = make_req(2, 10);
    push_one(a); push_one(b); push_one(c);
    finish_batch(25, "R4");
    chk(mqn == 1 && mq[0] == c, "R4", "last request set aside", mqn, 1);
    capacity = 19'd1000;
    begin_batch();
    @(negedge clk); free_event = 1'b1; t_free = cyc;
    @(negedge clk); free_event = 1'b0;
    finish_batch(1000, "R9");
    chk(done_cyc - t_free < 50, "R9", "free event start delay", done_cyc - t_free, 50);
    chk(gc == 1 && g_tag[0] == (c & 255), "R9", "queued request served", g_tag[0], c & 255);

    // R8: leftover leads next batch
    capacity = 19'd25;
    begin_batch();
    a = make_req(2, 10); b = make_req(2, 10); c = make_req(2, 10);
    push_one(a); push_one(b); push_one(c);
    finish_batch(25, "R4");
    capacity = 19'd5000;
    begin_batch();
    d = make_req(3, 40);
    push_one(d);
    finish_batch(5000, "R8");
    chk(g_tag[0] == (c & 255), "R8", "leftover first", g_tag[0], c & 255);

    // R3 full batch, R11 capacity held, R10 pushes refused
    cap = 12000;
    capacity = CAPW'(cap);
    begin_batch();
    for (int i = 0; i < 8; i++) begin
      a = make_req(int'($urandom_range(1, 8)), int'($urandom_range(1, 1000)));
      push_one(a);
    end
    chk(push_ready == 1'b0, "R3", "ready low after full", push_ready, 0);
    @(posedge clk); @(negedge clk);
    capacity = '0;
    push_valid = 1'b1; push_size = 16'd7; push_eff = 24'd9; push_last = 1'b1; push_tag = 8'hEE;
    for (int i = 0; i < 5; i++) begin
      chk(push_ready == 1'b0, "R10", "ready low while sizing", push_ready, 0);
      @(negedge clk);
    end
    push_valid = 1'b0; push_last = 1'b0;
    finish_batch(cap, "R11");
    chk(done_cyc - last_push_cyc < WIN, "R3", "no window wait", done_cyc - last_push_cyc, WIN);

    // Random batches (R5 and R12 under mixed curves)
    for (int r = 0; r < 14; r++) begin
      begin_batch();
      nnew = (mqn >= 8) ? 0 : int'($urandom_range(1, 8 - mqn));
      for (int i = 0; i < nnew; i++) begin
        a = make_req(int'($urandom_range(1, 8)), int'($urandom_range(1, 1000)));
        bl[bn] = a; bn++;
      end
      tsum = 0;
      for (int i = 0; i < bn; i++) tsum += int'(rq_sz[bl[i]][rq_n[bl[i]] - 1]);
      cap = int'($urandom_range(rq_sz[bl[0]][0], tsum));
      capacity = CAPW'(cap);
      bn = mqn;
      for (int i = 0; i < nnew; i++) push_one(nid - nnew + i);
      finish_batch(cap, "R5");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule